// File: doc/BRIEF.md
# Fuse-Map Programming Controller with Security Lock

This block holds the configuration memory of a small programmable-logic emulator: a grid of connection bits (one per product term and input line), a set of macrocell configuration bits, a security lock and a signature word. The memory is modelled as ordinary registers. The contents are driven straight out to the logic that the emulator builds from them. A programming agent changes the memory one command at a time over a valid/ready command port. It can erase everything, connect single bits, read single bits back, tie a whole product term off, set the lock, and write or read the signature.

Setting the lock hides the pattern and freezes it. Read-back of connection or configuration bits is refused, and so is any further programming. Only a bulk erase opens the lock again, and that erase wipes the pattern with it. The signature word can still be read while the lock is set. This lets an identifying code or revision number be checked on a protected part. Each command finishes one cycle after it is accepted. The result is one of three: a read response, a done pulse, or an error pulse.

Top module: `fuse_prog_ctrl`

## Requirements
- R1: In reset and in the cycle after it, every connection bit and configuration bit reads 0 (open), `locked` is 0, the signature is 0, and `rsp_valid`, `cmd_err` and `cmd_done` are 0.
- R2: A program command (op 1) sets the addressed bit to 1. Addresses below LINES*TERMS select connection bit term*LINES+line. Higher addresses select configuration bit addr-LINES*TERMS. No other bit changes. No command except erase turns a 1 back to 0.
- R3: An erase command (op 0) is always accepted. It clears every connection and configuration bit and the lock, and pulses `cmd_done` in the cycle after acceptance.
- R4: A verify command (op 2) on an unlocked device returns the addressed bit in `rsp_data[0]`, with the upper bits 0 and `rsp_valid` high, in the cycle after acceptance.
- R5: A lock command (op 3) sets `locked`. Program-and-lock (op 7) connects the addressed bit and sets `locked` in the same command. Both pulse `cmd_done`. The lock then stays set until an erase.
- R6: While locked, verify, program, program-and-lock, term kill and signature write are refused. The result is a one-cycle `cmd_err` pulse, no `rsp_valid`, and no stored bit changed.
- R7: A signature write (op 4) stores `cmd_data` and pulses `cmd_done`. A signature read (op 5) returns the stored word with `rsp_valid`, whether or not the device is locked.
- R8: With SIG_CLR_ON_ERASE=1 (the default), an erase also clears the signature word to 0.
- R9: A term kill (op 6) with a term index below TERMS in `cmd_addr` sets all LINES connection bits of that term to 1, which makes the term always false.
- R10: A program or verify address at or beyond LINES*TERMS+CFG_BITS, or a term kill index at or beyond TERMS, gives `cmd_err` and changes nothing.
- R11: `cmd_err`, `cmd_done` and `rsp_valid` are single-cycle pulses, and no two are high together. `cmd_done` follows only successful erase, program, lock, kill and signature-write commands.
- R12: `cmd_ready` is 0 during reset and 1 from the second cycle after reset is released. A command is taken only when `cmd_valid` and `cmd_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is presented |
| cmd_ready | output | 1 | The controller accepts commands |
| cmd_op | input | 3 | Operation code (0 erase … 7 program-and-lock) |
| cmd_addr | input | ADDR_W | Bit address, or term index for a kill |
| cmd_data | input | SIG_W | Signature value for a signature write |
| rsp_valid | output | 1 | Read data is valid this cycle |
| rsp_data | output | SIG_W | Read bit (bit 0) or signature word |
| cmd_err | output | 1 | The last accepted command was refused |
| cmd_done | output | 1 | The last accepted write-type command completed |
| locked | output | 1 | Security lock state |
| arr_conn | output | LINES*TERMS | Connection bits, index term*LINES+line |
| cell_cfg | output | CELLS*CFG_PER_CELL | Macrocell configuration bits |

## Verification
A wrong lock state shows at the next refused or accepted command: a verify that should be refused returns data, or a program goes through. The bit vectors exposed on `arr_conn` and `cell_cfg` show a corrupted bit one cycle after the command that caused it. A verify of that bit shows the same fault on `rsp_data` in the cycle after it is accepted. A signature kept or lost wrongly across an erase or while locked shows at the next signature read. A decode fault in the address map shows as a neighbouring bit that is set or missed.

// File: rtl/fuse_prog_pkg.sv
// Package: shared opcode and decoded-action types for the fuse-map controller.
// Assumes a 3-bit opcode field; every code value is used.
package fuse_prog_pkg;

    typedef enum logic [2:0] {
        OP_ERASE    = 3'd0,
        OP_SET      = 3'd1,
        OP_READ     = 3'd2,
        OP_LOCK     = 3'd3,
        OP_SIG_WR   = 3'd4,
        OP_SIG_RD   = 3'd5,
        OP_KILL     = 3'd6,
        OP_SET_LOCK = 3'd7
    } fuse_op_e;

    typedef struct packed {
        logic erase;
        logic set_bit;
        logic kill;
        logic lock;
        logic sig_wr;
        logic rd_bit;
        logic rd_sig;
        logic refuse;
    } fuse_act_t;

endpackage

// File: rtl/fuse_cmd_check.sv
// Command legality check: turns an accepted command into one set of
// action strobes, or a refusal when the lock or the address range forbids it.
// Purely combinational; assumes TOTAL and TERMS fit in 2^ADDR_W.
module fuse_cmd_check
    import fuse_prog_pkg::*;
#(
    parameter int TOTAL  = 136,
    parameter int TERMS  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              accept,
    input  logic [2:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              locked,
    output fuse_act_t         act
);

    logic bit_ok;
    logic term_ok;

    // Range checks on the address field.
    always_comb begin
        bit_ok  = ({1'b0, addr} < (ADDR_W+1)'(TOTAL));
        term_ok = ({1'b0, addr} < (ADDR_W+1)'(TERMS));
    end

    // Decode the opcode against lock state and range.
    always_comb begin
        act = '0;
        if (accept) begin
            unique case (fuse_op_e'(op))
                OP_ERASE:  act.erase = 1'b1;
                OP_SET: begin
                    if (locked || !bit_ok) act.refuse  = 1'b1;
                    else                   act.set_bit = 1'b1;
                end
                OP_READ: begin
                    if (locked || !bit_ok) act.refuse = 1'b1;
                    else                   act.rd_bit = 1'b1;
                end
                OP_LOCK:   act.lock = 1'b1;
                OP_SIG_WR: begin
                    if (locked) act.refuse = 1'b1;
                    else        act.sig_wr = 1'b1;
                end
                OP_SIG_RD: act.rd_sig = 1'b1;
                OP_KILL: begin
                    if (locked || !term_ok) act.refuse = 1'b1;
                    else                    act.kill   = 1'b1;
                end
                OP_SET_LOCK: begin
                    if (locked || !bit_ok) act.refuse = 1'b1;
                    else begin
                        act.set_bit = 1'b1;
                        act.lock    = 1'b1;
                    end
                end
                default: act.refuse = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/fuse_bit_store.sv
// Connection and configuration bit storage. A bit only goes 0->1 through
// a program or a term kill, and only goes back to 0 through erase or reset.
// Assumes the strobes are already qualified (legal, in range).
module fuse_bit_store #(
    parameter int LINES    = 8,
    parameter int TERMS    = 16,
    parameter int CFG_BITS = 8,
    parameter int ADDR_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     erase,
    input  logic                     set_bit,
    input  logic                     kill,
    input  logic [ADDR_W-1:0]        addr,
    output logic [LINES*TERMS-1:0]   arr_q,
    output logic [CFG_BITS-1:0]      cfg_q
);

    localparam int ARR_BITS = LINES * TERMS;

    for (genvar t = 0; t < TERMS; t++) begin : g_term
        logic kill_hit;
        // Kill strobe aimed at this term.
        assign kill_hit = kill && (addr == ADDR_W'(t));
        for (genvar l = 0; l < LINES; l++) begin : g_line
            localparam int IDX = t * LINES + l;
            logic set_hit;
            // Program strobe aimed at this bit.
            assign set_hit = set_bit && (addr == ADDR_W'(IDX));
            // One connection bit: erase opens, program or kill connects.
            always_ff @(posedge clk) begin
                if (!rst_n)                  arr_q[IDX] <= 1'b0;
                else if (erase)              arr_q[IDX] <= 1'b0;
                else if (kill_hit || set_hit) arr_q[IDX] <= 1'b1;
            end
        end
    end

    for (genvar c = 0; c < CFG_BITS; c++) begin : g_cfg
        localparam int IDX = ARR_BITS + c;
        logic set_hit;
        // Program strobe aimed at this configuration bit.
        assign set_hit = set_bit && (addr == ADDR_W'(IDX));
        // One configuration bit: erase clears, program sets.
        always_ff @(posedge clk) begin
            if (!rst_n)       cfg_q[c] <= 1'b0;
            else if (erase)   cfg_q[c] <= 1'b0;
            else if (set_hit) cfg_q[c] <= 1'b1;
        end
    end

endmodule

// File: rtl/fuse_sig_reg.sv
// Signature word register. Written only on a legal signature write.
// CLR_ON_ERASE selects whether a bulk erase also clears it.
module fuse_sig_reg #(
    parameter int SIG_W        = 24,
    parameter bit CLR_ON_ERASE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             erase,
    input  logic             wr,
    input  logic [SIG_W-1:0] wdata,
    output logic [SIG_W-1:0] sig_q
);

    logic erase_hit;

    if (CLR_ON_ERASE) begin : g_clr
        assign erase_hit = erase;
    end else begin : g_keep
        assign erase_hit = 1'b0;
    end

    // Signature storage update.
    always_ff @(posedge clk) begin
        if (!rst_n)         sig_q <= '0;
        else if (erase_hit) sig_q <= '0;
        else if (wr)        sig_q <= wdata;
    end

endmodule

// File: rtl/fuse_prog_ctrl.sv
// Fuse-map programming controller top. Accepts one command per cycle and
// answers each in the next cycle with a read response, a done pulse or an
// error pulse. Enforces the security lock. Assumes the agent holds a command
// on cmd_valid for one cycle per transfer.
module fuse_prog_ctrl
    import fuse_prog_pkg::*;
#(
    parameter int LINES            = 8,
    parameter int TERMS            = 16,
    parameter int CELLS            = 4,
    parameter int CFG_PER_CELL     = 2,
    parameter int SIG_W            = 24,
    parameter bit SIG_CLR_ON_ERASE = 1'b1,
    localparam int ARR_BITS        = LINES * TERMS,
    localparam int CFG_BITS        = CELLS * CFG_PER_CELL,
    localparam int TOTAL           = ARR_BITS + CFG_BITS,
    localparam int ADDR_W          = $clog2(TOTAL)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [2:0]          cmd_op,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [SIG_W-1:0]    cmd_data,
    output logic                rsp_valid,
    output logic [SIG_W-1:0]    rsp_data,
    output logic                cmd_err,
    output logic                cmd_done,
    output logic                locked,
    output logic [ARR_BITS-1:0] arr_conn,
    output logic [CFG_BITS-1:0] cell_cfg
);

    logic             ready_q;
    logic             lock_q;
    logic             accept;
    fuse_act_t        act;
    logic [SIG_W-1:0] sig_q;
    logic [TOTAL-1:0] all_bits;
    logic             rd_val;

    assign accept = cmd_valid && ready_q;

    fuse_cmd_check #(
        .TOTAL (TOTAL),
        .TERMS (TERMS),
        .ADDR_W(ADDR_W)
    ) u_check (
        .accept(accept),
        .op    (cmd_op),
        .addr  (cmd_addr),
        .locked(lock_q),
        .act   (act)
    );

    fuse_bit_store #(
        .LINES   (LINES),
        .TERMS   (TERMS),
        .CFG_BITS(CFG_BITS),
        .ADDR_W  (ADDR_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .erase  (act.erase),
        .set_bit(act.set_bit),
        .kill   (act.kill),
        .addr   (cmd_addr),
        .arr_q  (arr_conn),
        .cfg_q  (cell_cfg)
    );

    fuse_sig_reg #(
        .SIG_W       (SIG_W),
        .CLR_ON_ERASE(SIG_CLR_ON_ERASE)
    ) u_sig (
        .clk  (clk),
        .rst_n(rst_n),
        .erase(act.erase),
        .wr   (act.sig_wr),
        .wdata(cmd_data),
        .sig_q(sig_q)
    );

    // Read-back mux over the whole bit space.
    always_comb begin
        all_bits = {cell_cfg, arr_conn};
        rd_val   = all_bits[cmd_addr];
    end

    // Ready comes up one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // Security lock: set by lock commands, cleared only by erase.
    always_ff @(posedge clk) begin
        if (!rst_n)         lock_q <= 1'b0;
        else if (act.erase) lock_q <= 1'b0;
        else if (act.lock)  lock_q <= 1'b1;
    end

    // Completion pulses for the command accepted in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            cmd_err   <= 1'b0;
            cmd_done  <= 1'b0;
        end else begin
            rsp_valid <= act.rd_bit || act.rd_sig;
            cmd_err   <= act.refuse;
            cmd_done  <= act.erase || act.set_bit || act.kill
                         || act.lock || act.sig_wr;
        end
    end

    // Read data register, loaded only by a legal read.
    always_ff @(posedge clk) begin
        if (!rst_n)          rsp_data <= '0;
        else if (act.rd_sig) rsp_data <= sig_q;
        else if (act.rd_bit) rsp_data <= SIG_W'(rd_val);
    end

    assign cmd_ready = ready_q;
    assign locked    = lock_q;

endmodule

// File: rtl/fuse_prog_ctrl_chk.sv
// Checker for fuse_prog_ctrl: protocol, lock and erase properties over the
// top-level ports plus the internal signature register. Attached by bind.
module fuse_prog_ctrl_chk #(
    parameter int ADDR_W   = 8,
    parameter int SIG_W    = 24,
    parameter int ARR_BITS = 128,
    parameter int CFG_BITS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic                cmd_ready,
    input logic [2:0]          cmd_op,
    input logic [ADDR_W-1:0]   cmd_addr,
    input logic                rsp_valid,
    input logic [SIG_W-1:0]    rsp_data,
    input logic                cmd_err,
    input logic                cmd_done,
    input logic                locked,
    input logic [ARR_BITS-1:0] arr_conn,
    input logic [CFG_BITS-1:0] cell_cfg,
    input logic [SIG_W-1:0]    sig_q
);

    logic acc;
    assign acc = cmd_valid && cmd_ready;

    p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_err, cmd_done, rsp_valid}));

    p_erase_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (cmd_op == 3'd0) |=> cmd_done && !locked
                                   && (arr_conn == '0) && (cell_cfg == '0));

    p_open_only_by_erase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && (cmd_op == 3'd0)) |=> ((~arr_conn & $past(arr_conn)) == '0)
                                      && ((~cell_cfg & $past(cell_cfg)) == '0));

    p_locked_read_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc && locked && (cmd_op == 3'd2) |=> cmd_err && !rsp_valid);

    p_locked_prog_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc && locked && ((cmd_op == 3'd1) || (cmd_op == 3'd6) || (cmd_op == 3'd7))
        |=> cmd_err && $stable(arr_conn) && $stable(cell_cfg));

    p_lock_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        locked && !(acc && (cmd_op == 3'd0)) |=> locked);

    p_sig_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (cmd_op == 3'd5) |=> rsp_valid && (rsp_data == $past(sig_q)));

    p_ready_up_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cmd_ready);

endmodule

bind fuse_prog_ctrl fuse_prog_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .SIG_W   (SIG_W),
    .ARR_BITS(ARR_BITS),
    .CFG_BITS(CFG_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_op   (cmd_op),
    .cmd_addr (cmd_addr),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .cmd_err  (cmd_err),
    .cmd_done (cmd_done),
    .locked   (locked),
    .arr_conn (arr_conn),
    .cell_cfg (cell_cfg),
    .sig_q    (sig_q)
);

// File: tb/fuse_prog_ctrl_test.sv
`timescale 1ns/1ps
// Bench for fuse_prog_ctrl at default parameters (8 lines, 16 terms,
// 8 configuration bits, 24-bit signature, erase clears signature).
module fuse_prog_ctrl_test;

    localparam logic [2:0] ER = 3'd0, ST = 3'd1, RD = 3'd2, LK = 3'd3,
                           SW = 3'd4, SR = 3'd5, KL = 3'd6, SL = 3'd7;

    typedef struct packed {
        logic [2:0]  op;
        logic [7:0]  addr;
        logic [23:0] data;
        logic [2:0]  flags;   // {err, done, rsp_valid}
        logic [23:0] rd;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t TAB [NV] = '{
        '{RD, 8'd5,   24'h0,      3'b001, 24'h0,      8'd1},  // R1 fresh bit open
        '{ST, 8'd5,   24'h0,      3'b010, 24'h0,      8'd2},  // R2
        '{RD, 8'd5,   24'h0,      3'b001, 24'h1,      8'd4},  // R4
        '{RD, 8'd6,   24'h0,      3'b001, 24'h0,      8'd2},  // R2 neighbour
        '{ST, 8'd5,   24'h0,      3'b010, 24'h0,      8'd2},  // R2 reprogram
        '{RD, 8'd5,   24'h0,      3'b001, 24'h1,      8'd2},  // R2
        '{ST, 8'd130, 24'h0,      3'b010, 24'h0,      8'd2},  // R2 config bit 2
        '{RD, 8'd130, 24'h0,      3'b001, 24'h1,      8'd4},  // R4
        '{RD, 8'd129, 24'h0,      3'b001, 24'h0,      8'd4},  // R4
        '{ST, 8'd136, 24'h0,      3'b100, 24'h0,      8'd10}, // R10
        '{RD, 8'd200, 24'h0,      3'b100, 24'h0,      8'd10}, // R10
        '{KL, 8'd3,   24'h0,      3'b010, 24'h0,      8'd9},  // R9
        '{RD, 8'd24,  24'h0,      3'b001, 24'h1,      8'd9},  // R9
        '{RD, 8'd31,  24'h0,      3'b001, 24'h1,      8'd9},  // R9
        '{RD, 8'd32,  24'h0,      3'b001, 24'h0,      8'd9},  // R9
        '{RD, 8'd23,  24'h0,      3'b001, 24'h0,      8'd9},  // R9
        '{KL, 8'd16,  24'h0,      3'b100, 24'h0,      8'd10}, // R10
        '{SW, 8'd0,   24'hA5C3E1, 3'b010, 24'h0,      8'd7},  // R7
        '{SR, 8'd0,   24'h0,      3'b001, 24'hA5C3E1, 8'd7},  // R7
        '{LK, 8'd0,   24'h0,      3'b010, 24'h0,      8'd5},  // R5
        '{RD, 8'd5,   24'h0,      3'b100, 24'h0,      8'd6},  // R6
        '{ST, 8'd7,   24'h0,      3'b100, 24'h0,      8'd6},  // R6
        '{KL, 8'd0,   24'h0,      3'b100, 24'h0,      8'd6},  // R6
        '{SR, 8'd0,   24'h0,      3'b001, 24'hA5C3E1, 8'd7},  // R7 while locked
        '{SW, 8'd0,   24'h123456, 3'b100, 24'h0,      8'd6},  // R6
        '{SR, 8'd0,   24'h0,      3'b001, 24'hA5C3E1, 8'd6},  // R6 sig unchanged
        '{LK, 8'd0,   24'h0,      3'b010, 24'h0,      8'd5},  // R5 relock
        '{ER, 8'd0,   24'h0,      3'b010, 24'h0,      8'd3},  // R3
        '{RD, 8'd5,   24'h0,      3'b001, 24'h0,      8'd3},  // R3
        '{RD, 8'd24,  24'h0,      3'b001, 24'h0,      8'd3},  // R3
        '{RD, 8'd130, 24'h0,      3'b001, 24'h0,      8'd3},  // R3
        '{SR, 8'd0,   24'h0,      3'b001, 24'h0,      8'd8},  // R8
        '{SL, 8'd9,   24'h0,      3'b010, 24'h0,      8'd5},  // R5 program+lock
        '{RD, 8'd9,   24'h0,      3'b100, 24'h0,      8'd5},  // R5
        '{ER, 8'd0,   24'h0,      3'b010, 24'h0,      8'd3},  // R3
        '{RD, 8'd9,   24'h0,      3'b001, 24'h0,      8'd3}   // R3
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [2:0]   cmd_op = 3'd0;
    logic [7:0]   cmd_addr = 8'd0;
    logic [23:0]  cmd_data = 24'd0;
    logic         rsp_valid;
    logic [23:0]  rsp_data;
    logic         cmd_err;
    logic         cmd_done;
    logic         locked;
    logic [127:0] arr_conn;
    logic [7:0]   cell_cfg;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fuse_prog_ctrl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready),
        .cmd_op   (cmd_op),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data),
        .cmd_err  (cmd_err),
        .cmd_done (cmd_done),
        .locked   (locked),
        .arr_conn (arr_conn),
        .cell_cfg (cell_cfg)
    );

    task automatic chk(input int req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one command at a falling edge, sample at the next falling edge.
    task automatic do_cmd(input logic [2:0] op, input logic [7:0] addr, input logic [23:0] data);
        cmd_op    = op;
        cmd_addr  = addr;
        cmd_data  = data;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [127:0] snap;
        repeat (3) @(negedge clk);
        // R1 / R12: state while in reset
        chk(12, 128'(cmd_ready), 128'd0);
        chk(1, arr_conn, 128'd0);
        chk(1, {cell_cfg, locked, rsp_valid, cmd_err, cmd_done}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: ready after reset release
        chk(12, 128'(cmd_ready), 128'd1);

        for (int i = 0; i < NV; i++) begin
            do_cmd(TAB[i].op, TAB[i].addr, TAB[i].data);
            // R11: pulse pattern per command
            chk(int'(TAB[i].req), 128'({cmd_err, cmd_done, rsp_valid}), 128'(TAB[i].flags));
            if (TAB[i].flags[0])
                chk(int'(TAB[i].req), 128'(rsp_data), 128'(TAB[i].rd));
        end

        // R11: pulses drop in the idle cycle after a command
        @(negedge clk);
        chk(11, 128'({cmd_err, cmd_done, rsp_valid}), 128'd0);

        // R12: command without valid is ignored
        cmd_op = ST; cmd_addr = 8'd50;
        repeat (2) @(negedge clk);
        chk(12, 128'({arr_conn[50], cmd_done}), 128'd0);

        // R9: kill of the last term seen on the bit vector
        do_cmd(KL, 8'd15, 24'h0);
        chk(9, arr_conn, {8'hFF, 120'd0});

        // R5 / R6: lock visible at the port, refused program leaves bits alone
        do_cmd(LK, 8'd0, 24'h0);
        chk(5, 128'(locked), 128'd1);
        snap = arr_conn;
        do_cmd(ST, 8'd50, 24'h0);
        chk(6, 128'(cmd_err), 128'd1);
        chk(6, arr_conn, snap);
        do_cmd(ST, 8'd131, 24'h0);
        chk(6, 128'(cell_cfg), 128'd0);

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        chk(12, 128'(cmd_ready), 128'd0);
        chk(1, {arr_conn}, 128'd0);
        chk(1, 128'(locked), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        do_cmd(SR, 8'd0, 24'h0);
        chk(1, 128'(rsp_data), 128'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule